// File: doc/BRIEF.md
# Request-Driven Clock Output Gate

This block owns a bank of free-running clock outputs and switches selected outputs off and back on in response to two active-low request lines. Either request line may change at any moment with no relation to the reference clock. Each line passes through a two-flop synchroniser and then a stability filter, and only a filtered level reaches the gating logic. Two mask registers, loaded through a plain write strobe, say which outputs each request line may stop. An output whose bits are clear in both masks never stops.

Each output is modelled as a true/complement pair that toggles on every reference rising edge, plus an output-enable. When every request that governs an output has been withdrawn, the output stops on the edge where its true side falls and then stays parked: both sides low and the enable low. When any governing request returns, every parked output restarts on the next edge where the true side rises, all of them on the same edge, so the first high phase has full width.

Top module: `req_clock_gate`

## Requirements
- R1: A running output has `clkOe` high, and its `clkT` toggles on every reference rising edge with `clkC` as its inverse. Counting rising edges after reset release from 1, `clkT` is high after every odd-numbered edge.
- R2: A request level is accepted only once its synchronised value has held across two consecutive rising edges. A change driven just after edge k is accepted at edge k+4. A high pulse lasting one reference period is ignored. A pulse lasting two periods is accepted.
- R3: When `wrEn` is high at a rising edge, `wrData` loads into the A mask if `wrSel`=0 and into the B mask if `wrSel`=1. Bit i set in a mask makes output i stoppable by that request line.
- R4: An output whose bit is clear in both masks keeps running whatever the request lines do.
- R5: When no mapped request of an output is accepted as asserted (low), the output stops at the first rising edge after acceptance at which its `clkT` falls. From that edge on, `clkT`, `clkC` and `clkOe` are all 0.
- R6: When a mapped request is accepted as asserted, each stopped output restarts at the first rising edge after acceptance at which `clkT` rises. All such outputs restart on the same edge, 5 or 6 edges after the input change.
- R7: An output set in both masks keeps running, or restarts, while either request line is asserted.
- R8: Reset clears both masks, treats both requests as asserted and leaves every output running with `clkT` low.
- R9: A mask write governs gating from the edge on which it loads, including when that edge is also the edge on which a request change is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqAN | input | 1 | Request line A, active low, asynchronous |
| reqBN | input | 1 | Request line B, active low, asynchronous |
| wrEn | input | 1 | Mask write strobe |
| wrSel | input | 1 | Mask select: 0 = A mask, 1 = B mask |
| wrData | input | GATE_OUTS | Mask value to load |
| clkT | output | GATE_OUTS | True side of each output clock |
| clkC | output | GATE_OUTS | Complement side of each output clock |
| clkOe | output | GATE_OUTS | Drive enable of each output pair |

## Verification
A mask write and the acceptance of a filtered request change can land on the same reference edge. The bench withdraws request B and then raises the write strobe three periods later. The new B mask therefore loads on exactly the edge at which the filter accepts the withdrawal. The result is judged by which outputs stop: only the output named by the new mask may park, while the outputs named only by the old mask must keep toggling.

// File: rtl/req_gate_pkg.sv
package req_gate_pkg;
  parameter int GATE_OUTS = 8;
  parameter int REQ_LINES = 2;

  typedef struct packed {
    logic [GATE_OUTS-1:0] stopStb;
    logic [GATE_OUTS-1:0] startStb;
  } gateCmd_t;
endpackage

// File: rtl/req_filter.sv
module req_filter (
  input  logic clk,
  input  logic rstN,
  input  logic reqN,
  output logic heldN
);
  logic metaQ, syncQ, prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= 1'b0;
      syncQ <= 1'b0;
      prevQ <= 1'b0;
      heldN <= 1'b0;
    end else begin
      metaQ <= reqN;
      syncQ <= metaQ;
      prevQ <= syncQ;
      if (syncQ == prevQ) heldN <= syncQ;
    end
  end

  AST_FILTER_TWO_EDGES: assert property (@(posedge clk) disable iff (!rstN)
    (heldN != $past(heldN)) |-> ($past(syncQ) == heldN && $past(prevQ) == heldN)); // R2
endmodule

// File: rtl/req_gate_ctrl.sv
module req_gate_ctrl import req_gate_pkg::*; (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqAN,
  input  logic                 reqBN,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [GATE_OUTS-1:0] wrData,
  input  logic                 phase,
  output gateCmd_t             cmd
);
  logic [REQ_LINES-1:0] reqN;
  logic [REQ_LINES-1:0] heldN;
  logic [GATE_OUTS-1:0] mask [REQ_LINES];
  logic [GATE_OUTS-1:0] wanted;

  assign reqN = {reqBN, reqAN};

  for (genvar g = 0; g < REQ_LINES; g++) begin : gFilt
    req_filter uFilt (.clk(clk), .rstN(rstN), .reqN(reqN[g]), .heldN(heldN[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REQ_LINES; r++) mask[r] <= '0;
    end else if (wrEn) begin
      mask[wrSel] <= wrData;
    end
  end

  always_comb begin
    for (int i = 0; i < GATE_OUTS; i++) begin
      wanted[i] = !(mask[0][i] || mask[1][i]) ||
                  (mask[0][i] && !heldN[0]) ||
                  (mask[1][i] && !heldN[1]);
    end
    cmd.stopStb  = phase ? ~wanted : '0;
    cmd.startStb = phase ? '0 : wanted;
  end

  for (genvar r = 0; r < REQ_LINES; r++) begin : gMaskChk
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrSel == r[0]) |=> mask[r] == $past(wrData)); // R3
  end

  for (genvar i = 0; i < GATE_OUTS; i++) begin : gOutChk
    AST_UNMAPPED_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
      (!mask[0][i] && !mask[1][i]) |-> !cmd.stopStb[i]); // R4
    AST_EITHER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (mask[0][i] && mask[1][i] && (!heldN[0] || !heldN[1])) |-> !cmd.stopStb[i]); // R7
  end
endmodule

// File: rtl/req_gate_dp.sv
module req_gate_dp import req_gate_pkg::*; (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateCmd_t             cmd,
  output logic                 phase,
  output logic [GATE_OUTS-1:0] clkT,
  output logic [GATE_OUTS-1:0] clkC,
  output logic [GATE_OUTS-1:0] clkOe
);
  logic [GATE_OUTS-1:0] stopped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 1'b0;
      stopped <= '0;
    end else begin
      phase   <= ~phase;
      stopped <= (stopped | cmd.stopStb) & ~cmd.startStb;
    end
  end

  assign clkOe = ~stopped;
  assign clkT  = {GATE_OUTS{phase}} & ~stopped;
  assign clkC  = {GATE_OUTS{~phase}} & ~stopped;

  for (genvar i = 0; i < GATE_OUTS; i++) begin : gChk
    AST_STOP_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stopped[i]) |-> ($past(clkT[i]) && !clkT[i] && !clkC[i])); // R5
    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(stopped[i]) |-> (clkT[i] && !$past(clkT[i]))); // R6
  end
endmodule

// File: rtl/req_clock_gate.sv
module req_clock_gate import req_gate_pkg::*; (
  input  logic                 refClk,
  input  logic                 rstN,
  input  logic                 reqAN,
  input  logic                 reqBN,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [GATE_OUTS-1:0] wrData,
  output logic [GATE_OUTS-1:0] clkT,
  output logic [GATE_OUTS-1:0] clkC,
  output logic [GATE_OUTS-1:0] clkOe
);
  gateCmd_t cmd;
  logic     phase;

  req_gate_ctrl uCtrl (
    .clk(refClk), .rstN(rstN), .reqAN(reqAN), .reqBN(reqBN),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .phase(phase), .cmd(cmd)
  );

  req_gate_dp uDp (
    .clk(refClk), .rstN(rstN), .cmd(cmd), .phase(phase),
    .clkT(clkT), .clkC(clkC), .clkOe(clkOe)
  );
endmodule

// File: tb/tb_req_clock_gate.sv
module tb_req_clock_gate;
  localparam int CLK_PERIOD = 10;
  localparam int N = req_gate_pkg::GATE_OUTS;

  logic refClk = 1'b0, rstN = 1'b0, reqAN = 1'b0, reqBN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] clkT, clkC, clkOe;

  req_clock_gate dut (.refClk(refClk), .rstN(rstN), .reqAN(reqAN), .reqBN(reqBN),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .clkT(clkT), .clkC(clkC), .clkOe(clkOe));

  always #(CLK_PERIOD/2) refClk = ~refClk;

  typedef struct { int at; logic [N-1:0] oe; string tag; } expItem_t;
  expItem_t expQ[$];
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always @(posedge refClk) if (rstN) cyc <= cyc + 1;

  task automatic expect_oe(int at, logic [N-1:0] oe, string tag);
    expItem_t it;
    it.at = at; it.oe = oe; it.tag = tag;
    expQ.push_back(it);
  endtask

  function automatic int next_edge(int after, int parity);
    int e = after + 1;
    if (e % 2 != parity) e++;
    return e;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge refClk);
  endtask

  // Monitor: pops expected enables and checks the pair against the enable (R1)
  always @(negedge refClk) begin
    if (rstN && !finished) begin
      logic [N-1:0] expT, expC;
      expT = clkOe & {N{cyc[0]}};
      expC = clkOe & ~{N{cyc[0]}};
      checks++;
      if (clkT !== expT || clkC !== expC) begin
        errors++;
        $display("FAIL R1 cycle %0d: clkT=%b clkC=%b expected %b %b", cyc, clkT, clkC, expT, expC);
      end
      while (expQ.size() > 0 && expQ[0].at <= cyc) begin
        checks++;
        if (expQ[0].at != cyc || clkOe !== expQ[0].oe) begin
          errors++;
          $display("FAIL %s cycle %0d: clkOe=%b expected %b", expQ[0].tag, cyc, clkOe, expQ[0].oe);
        end
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c, e, r, e2, r2;
    tick(3);
    checks++; // R8 reset state
    if (clkOe !== {N{1'b1}} || clkT !== '0) begin
      errors++;
      $display("FAIL R8 reset: clkOe=%b clkT=%b expected %b %b", clkOe, clkT, {N{1'b1}}, {N{1'b0}});
    end
    rstN = 1'b1;
    tick(4);

    // R8/R4: masks clear after reset, so a withdrawn request stops nothing
    reqAN = 1'b1; c = cyc;
    for (int k = 1; k <= 12; k++) expect_oe(c + k, 8'hFF, "R8 R4 masks clear");
    tick(14);
    reqAN = 1'b0;
    tick(8);

    // R3: load A mask 0x0F and B mask 0x3C
    wrEn = 1'b1; wrSel = 1'b0; wrData = 8'h0F; tick(1);
    wrSel = 1'b1; wrData = 8'h3C; tick(1);
    wrEn = 1'b0; tick(2);

    // R5/R7: A withdrawn stops 0,1 only; 2,3 held by B
    reqAN = 1'b1; c = cyc;
    e = next_edge(c + 4, 0);
    expect_oe(e - 1, 8'hFF, "R5 before stop");
    expect_oe(e, 8'hFC, "R5 R7 R3 stop A");
    tick(e - c + 3);

    // R5/R4: B withdrawn stops 2..5; 6,7 unmapped keep running
    reqBN = 1'b1; c = cyc;
    e = next_edge(c + 4, 0);
    expect_oe(e - 1, 8'hFC, "R5 before stop B");
    expect_oe(e, 8'hC0, "R5 R4 stop B");
    tick(e - c + 3);

    // R6/R7: A asserted restarts 0..3 together; 4,5 stay parked
    reqAN = 1'b0; c = cyc;
    r = next_edge(c + 4, 1);
    expect_oe(r - 1, 8'hC0, "R6 before restart");
    expect_oe(r, 8'hCF, "R6 R7 restart A");
    tick(r - c + 3);

    // R2: one-period pulse on A is ignored
    reqAN = 1'b1; c = cyc;
    for (int k = 1; k <= 10; k++) expect_oe(c + k, 8'hCF, "R2 short pulse ignored");
    tick(1);
    reqAN = 1'b0;
    tick(11);

    // R2: two-period pulse on A is accepted, stops 0..3, then restarts
    reqAN = 1'b1; c = cyc;
    e2 = next_edge(c + 4, 0);
    r2 = next_edge(c + 6, 1);
    expect_oe(e2 - 1, 8'hCF, "R2 before stop");
    expect_oe(e2, 8'hC0, "R2 two-edge pulse stop");
    expect_oe(r2 - 1, 8'hC0, "R2 before restart");
    expect_oe(r2, 8'hCF, "R2 R6 restart");
    tick(2);
    reqAN = 1'b0;
    tick(r2 - c + 1);

    // R6: B asserted restarts 4,5
    reqBN = 1'b0; c = cyc;
    r = next_edge(c + 4, 1);
    expect_oe(r - 1, 8'hCF, "R6 before restart B");
    expect_oe(r, 8'hFF, "R6 restart B");
    tick(r - c + 3);

    // R9: B withdrawn; new B mask 0x80 loads on the acceptance edge
    reqBN = 1'b1; c = cyc;
    e = next_edge(c + 4, 0);
    expect_oe(e - 1, 8'hFF, "R9 before stop");
    expect_oe(e, 8'h7F, "R9 coincident write");
    tick(3);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 8'h80;
    tick(1);
    wrEn = 1'b0;
    tick(e - c + 2);
    for (int k = 1; k <= 4; k++) expect_oe(cyc + k, 8'h7F, "R9 R4 after write");
    tick(6);

    finished = 1;
    while (expQ.size() > 0) begin
      checks++; errors++;
      $display("FAIL %s: item at cycle %0d never checked, expected %b", expQ[0].tag, expQ[0].at, expQ[0].oe);
      void'(expQ.pop_front());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule